// File: doc/BRIEF.md
# External Sync Vertical Realignment

This block decides whether a camera timing generator runs from its own timebase or follows an external reference. It looks at three sync pins: a horizontal reference pin, a combined vertical/composite pin and a level pin that asks for separate H/V locking. An undriven pin sits at its pulled level (high for the two reference pins, low for the select pin). The block reports its choice on a status output. In either external mode it also issues a one-cycle request that realigns the downstream vertical line counter.

With composite sync on the vertical/composite pin, a vertical reference pulse is taken on its own input. That pulse is assumed to be already separated out of the composite waveform. The realign request falls a fixed number of line strobes after the pulse's falling edge, and the count depends on the selected line standard. With separate H and V references, the external VD falling edge is timed against the locked internal line strobe. A VD pulse that stays low across two line strobes is accepted. The request then carries a load value of one line, because the internal VD is meant to have fallen one line after the external edge. The half of the line in which the edge arrived sets the odd/even field flag.

Top module: `sync_realign`

## Requirements
- R1: After reset, extOut is 0, vResetOut is 0 and fieldOdd is 1.
- R2: With extSelIn low and no edges on hdIn or vdSyncIn, extOut is 0 and no realign request is issued, even when vrefIn falls.
- R3: With extSelIn low, an edge on vdSyncIn within the last ACT_LINES line strobes, and no edge on hdIn for HD_LOSS_LINES strobes, the composite mode is selected and extOut is 1.
- R4: With extSelIn high and recent edges on both hdIn and vdSyncIn, the separate H/V mode is selected and extOut is 1.
- R5: In composite mode with ccirSel = 0, vResetOut pulses for exactly one cycle, in the cycle after the 259th sampled line strobe that follows a vrefIn falling edge, and vLoadLine is 0.
- R6: In composite mode with ccirSel = 1, the request comes after the 309th line strobe instead, again with vLoadLine = 0.
- R7: In separate H/V mode, vResetOut pulses in the cycle after the second line strobe that follows a detected vdSyncIn fall, provided the pin is still low. vLoadLine is then 1, meaning the internal VD fell at the first of those strobes.
- R8: The phase of a vdSyncIn fall is taken as the clock count since the last line strobe, measured at detection (3 clocks after the pin changes). A count below LINE_CLKS/2 gives fieldOdd = 1; otherwise fieldOdd = 0. fieldOdd changes only together with a vResetOut pulse.
- R9: A vdSyncIn low pulse that rises before the second line strobe is ignored: no request is issued and fieldOdd keeps its value.
- R10: An external reference remains selected across vertical periods of up to ACT_LINES line strobes without a vdSyncIn edge. After ACT_LINES strobes with no edge, or HD_LOSS_LINES strobes with no hdIn edge in H/V mode, extOut returns to 0.
- R11: A new vrefIn fall while a composite count is running restarts the count from that fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdIn | input | 1 | External horizontal reference pin, idles high |
| vdSyncIn | input | 1 | External VD or composite sync pin, idles high |
| vrefIn | input | 1 | Vertical reference pulse extracted from composite sync, active low |
| extSelIn | input | 1 | High requests separate H/V locking, idles low |
| lineStb | input | 1 | One-cycle strobe at the start of each locked internal line |
| ccirSel | input | 1 | Line standard: 0 selects the 525-line count, 1 the 625-line count |
| extOut | output | 1 | 1 while an external reference is followed |
| vResetOut | output | 1 | One-cycle vertical counter realign request |
| vLoadLine | output | $clog2(MIN_VD_LINES+1) | Line index to load with the request |
| fieldOdd | output | 1 | Field decision, 1 for odd |

## Verification
A stuck or miscounted line counter would put vResetOut on the wrong strobe. That shows up a full field later as a strobe count off by one or more, or as a missing or doubled pulse within the window. A wrong phase capture or a stale pending flag would flip fieldOdd, which becomes visible in the same cycle as the next accepted request. A bad activity timer or mode decode would make extOut disagree with the pin pattern a few line strobes after the pins settle, or at the ACT_LINES boundary. The bench therefore counts line strobes between each stimulus edge and the request, and samples extOut on both sides of each timeout.

// File: rtl/sync_realign_pkg.sv
package sync_realign_pkg;

  typedef enum logic [1:0] {
    MODE_INT   = 2'd0,
    MODE_CSYNC = 2'd1,
    MODE_VDHD  = 2'd2
  } syncMode_e;

  typedef struct packed {
    logic      lineTick;
    logic      vdFall;
    logic      vdRise;
    logic      refFall;
    syncMode_e mode;
  } ctrlStrobe_t;

endpackage

// File: rtl/sync_realign_ctrl.sv
module sync_realign_ctrl
  import sync_realign_pkg::*;
#(
  parameter int HD_LOSS_LINES = 4,
  parameter int ACT_LINES     = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hdIn,
  input  logic        vdSyncIn,
  input  logic        vrefIn,
  input  logic        extSelIn,
  input  logic        lineStb,
  output ctrlStrobe_t strb,
  output logic        extOut
);

  localparam int NPIN = 4;
  localparam int NACT = 2;
  localparam int TW   = $clog2(ACT_LINES + 1);
  localparam logic [NPIN-1:0] IDLE_LVL = 4'b0111;

  logic [NPIN-1:0] rawPins;
  logic [NPIN-1:0] syncA;
  logic [NPIN-1:0] syncB;
  logic [NPIN-2:0] syncC;
  logic [NACT-1:0] pinEdge;
  logic [NACT-1:0] pinActive;
  logic [TW-1:0]   actTmr [NACT];
  syncMode_e       modeQ;
  syncMode_e       modeNext;

  assign rawPins = {extSelIn, vrefIn, vdSyncIn, hdIn};

  // two-stage synchronizers; the three edge-sensitive pins get a third stage
  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA[i] <= IDLE_LVL[i];
        syncB[i] <= IDLE_LVL[i];
      end else begin
        syncA[i] <= rawPins[i];
        syncB[i] <= syncA[i];
      end
    end
    if (i < NPIN - 1) begin : g_edge
      always_ff @(posedge clk) begin
        if (!rstN) syncC[i] <= IDLE_LVL[i];
        else       syncC[i] <= syncB[i];
      end
    end
  end

  // line-based activity timers: 0 = hd pin, 1 = vd/sync pin
  for (genvar c = 0; c < NACT; c++) begin : g_act
    localparam int LIM = (c == 0) ? HD_LOSS_LINES : ACT_LINES;
    assign pinEdge[c] = syncB[c] ^ syncC[c];
    always_ff @(posedge clk) begin
      if (!rstN)                                actTmr[c] <= TW'(LIM);
      else if (pinEdge[c])                      actTmr[c] <= '0;
      else if (lineStb && actTmr[c] < TW'(LIM)) actTmr[c] <= actTmr[c] + 1'b1;
    end
    assign pinActive[c] = actTmr[c] < TW'(LIM);
  end

  always_comb begin
    if (syncB[3] && pinActive[0] && pinActive[1])       modeNext = MODE_VDHD;
    else if (!syncB[3] && pinActive[1] && !pinActive[0]) modeNext = MODE_CSYNC;
    else                                                 modeNext = MODE_INT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_INT;
    else       modeQ <= modeNext;
  end

  assign extOut        = (modeQ != MODE_INT);
  assign strb.lineTick = lineStb;
  assign strb.vdFall   = syncC[1] & ~syncB[1];
  assign strb.vdRise   = ~syncC[1] & syncB[1];
  assign strb.refFall  = syncC[2] & ~syncB[2];
  assign strb.mode     = modeQ;

  // R10: both reference pins timed out means internal timing next cycle
  p_quiet_pins_internal_r10: assert property (@(posedge clk) disable iff (!rstN)
    (actTmr[0] == TW'(HD_LOSS_LINES) && actTmr[1] == TW'(ACT_LINES)) |=> !extOut);

  // R3: composite mode never follows a cycle with a live hd pin
  p_csync_no_hd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_CSYNC) |-> $past(!pinActive[0]));

endmodule

// File: rtl/sync_realign_dp.sv
module sync_realign_dp
  import sync_realign_pkg::*;
#(
  parameter int LINE_CLKS    = 606,
  parameter int EIA_LINES    = 259,
  parameter int CCIR_LINES   = 309,
  parameter int MIN_VD_LINES = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobe_t                       strb,
  input  logic                              ccirSel,
  output logic                              vResetOut,
  output logic [$clog2(MIN_VD_LINES+1)-1:0] vLoadLine,
  output logic                              fieldOdd
);

  localparam int HW    = $clog2(LINE_CLKS);
  localparam int HALF  = LINE_CLKS / 2;
  localparam int MAXL  = (EIA_LINES > CCIR_LINES) ? EIA_LINES : CCIR_LINES;
  localparam int CW    = $clog2(MAXL + 1);
  localparam int LW    = $clog2(MIN_VD_LINES + 1);
  localparam int VW    = $clog2(MIN_VD_LINES + 1);

  logic [HW-1:0] hCnt;
  logic [CW-1:0] cCnt;
  logic [CW-1:0] cTarget;
  logic          cArm;
  logic [VW-1:0] vCnt;
  logic          vArm;
  logic          vOddPend;
  logic          cFire;
  logic          vFire;
  logic          inCsync;
  logic          inVdhd;

  assign inCsync = (strb.mode == MODE_CSYNC);
  assign inVdhd  = (strb.mode == MODE_VDHD);
  assign cTarget = ccirSel ? CW'(CCIR_LINES) : CW'(EIA_LINES);

  // clocks since the last locked line strobe
  always_ff @(posedge clk) begin
    if (!rstN)                          hCnt <= '0;
    else if (strb.lineTick)             hCnt <= '0;
    else if (hCnt != HW'(LINE_CLKS-1))  hCnt <= hCnt + 1'b1;
  end

  assign cFire = inCsync && !strb.refFall && cArm && strb.lineTick &&
                 (cCnt >= cTarget - 1'b1);
  assign vFire = inVdhd && !strb.vdFall && !strb.vdRise && vArm &&
                 strb.lineTick && (vCnt == VW'(MIN_VD_LINES - 1));

  // composite: count line strobes after the reference fall
  always_ff @(posedge clk) begin
    if (!rstN || !inCsync) begin
      cArm <= 1'b0;
      cCnt <= '0;
    end else if (strb.refFall) begin
      cArm <= 1'b1;
      cCnt <= '0;
    end else if (cFire) begin
      cArm <= 1'b0;
    end else if (cArm && strb.lineTick) begin
      cCnt <= cCnt + 1'b1;
    end
  end

  // separate H/V: capture phase, then qualify the low width in lines
  always_ff @(posedge clk) begin
    if (!rstN || !inVdhd) begin
      vArm     <= 1'b0;
      vCnt     <= '0;
      vOddPend <= 1'b0;
    end else if (strb.vdFall) begin
      vArm     <= 1'b1;
      vCnt     <= '0;
      vOddPend <= (hCnt < HW'(HALF));
    end else if (strb.vdRise || vFire) begin
      vArm <= 1'b0;
    end else if (vArm && strb.lineTick) begin
      vCnt <= vCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vResetOut <= 1'b0;
      vLoadLine <= '0;
      fieldOdd  <= 1'b1;
    end else begin
      vResetOut <= cFire | vFire;
      if (vFire) begin
        vLoadLine <= LW'(MIN_VD_LINES - 1);
        fieldOdd  <= vOddPend;
      end else if (cFire) begin
        vLoadLine <= '0;
      end
    end
  end

  // R5: the request is a single-cycle pulse
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    vResetOut |=> !vResetOut);

  // R8: the field flag moves only with an accepted request
  p_field_with_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fieldOdd) |-> vResetOut);

  // R9: the width qualifier never runs past the acceptance point
  p_vcnt_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    vArm |-> (vCnt < VW'(MIN_VD_LINES)));

  // R7: a request loads either the composite or the H/V line index
  p_load_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    vResetOut |-> (vLoadLine == '0 || vLoadLine == LW'(MIN_VD_LINES - 1)));

endmodule

// File: rtl/sync_realign.sv
module sync_realign
  import sync_realign_pkg::*;
#(
  parameter int LINE_CLKS     = 606,
  parameter int EIA_LINES     = 259,
  parameter int CCIR_LINES    = 309,
  parameter int MIN_VD_LINES  = 2,
  parameter int HD_LOSS_LINES = 4,
  parameter int ACT_LINES     = 1024
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              hdIn,
  input  logic                              vdSyncIn,
  input  logic                              vrefIn,
  input  logic                              extSelIn,
  input  logic                              lineStb,
  input  logic                              ccirSel,
  output logic                              extOut,
  output logic                              vResetOut,
  output logic [$clog2(MIN_VD_LINES+1)-1:0] vLoadLine,
  output logic                              fieldOdd
);

  ctrlStrobe_t strb;

  sync_realign_ctrl #(
    .HD_LOSS_LINES(HD_LOSS_LINES),
    .ACT_LINES    (ACT_LINES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hdIn    (hdIn),
    .vdSyncIn(vdSyncIn),
    .vrefIn  (vrefIn),
    .extSelIn(extSelIn),
    .lineStb (lineStb),
    .strb    (strb),
    .extOut  (extOut)
  );

  sync_realign_dp #(
    .LINE_CLKS   (LINE_CLKS),
    .EIA_LINES   (EIA_LINES),
    .CCIR_LINES  (CCIR_LINES),
    .MIN_VD_LINES(MIN_VD_LINES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ccirSel  (ccirSel),
    .vResetOut(vResetOut),
    .vLoadLine(vLoadLine),
    .fieldOdd (fieldOdd)
  );

  // R2: a request only follows a cycle spent in an external mode
  p_reset_needs_ext_r2: assert property (@(posedge clk) disable iff (!rstN)
    vResetOut |-> $past(extOut));

endmodule

// File: tb/sync_realign_test.sv
`timescale 1ns/1ps
module sync_realign_test;

  localparam int LC = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdIn = 1'b1, vdSyncIn = 1'b1, vrefIn = 1'b1, extSelIn = 1'b0;
  logic lineStb = 1'b0, ccirSel = 1'b0;
  logic extOut, vResetOut, fieldOdd;
  logic [1:0] vLoadLine;

  sync_realign #(.LINE_CLKS(LC)) uut (
    .clk(clk), .rstN(rstN), .hdIn(hdIn), .vdSyncIn(vdSyncIn), .vrefIn(vrefIn),
    .extSelIn(extSelIn), .lineStb(lineStb), .ccirSel(ccirSel),
    .extOut(extOut), .vResetOut(vResetOut), .vLoadLine(vLoadLine),
    .fieldOdd(fieldOdd)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int ph = 0, strobeCnt = 0, resetCnt = 0, lastCnt = 0;
  int vdLow = 0, refLow = 0;
  logic prevStb = 1'b0, hdOn = 1'b0, csyncOn = 1'b0;
  logic [1:0] lastLoad = '0;

  typedef struct packed {
    logic       isVdhd;
    logic       ccir;
    logic [7:0] fallPh;
    logic [7:0] width;
    logic [9:0] waitLines;
    logic [3:0] expResets;
    logic [9:0] expCnt;
    logic [1:0] expLoad;
    logic       expField;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b0, 8'd8,  8'd8,  10'd262, 4'd1, 10'd259, 2'd0, 1'b1},  // R5
    '{1'b0, 1'b1, 8'd8,  8'd8,  10'd312, 4'd1, 10'd309, 2'd0, 1'b1},  // R6
    '{1'b1, 1'b0, 8'd4,  8'd96, 10'd4,   4'd1, 10'd2,   2'd1, 1'b1},  // R7 R8 odd
    '{1'b1, 1'b0, 8'd20, 8'd96, 10'd4,   4'd1, 10'd2,   2'd1, 1'b0},  // R8 even
    '{1'b1, 1'b0, 8'd4,  8'd20, 10'd4,   4'd0, 10'd0,   2'd0, 1'b0},  // R9 no strobe
    '{1'b1, 1'b0, 8'd20, 8'd40, 10'd4,   4'd0, 10'd0,   2'd0, 1'b0},  // R9 one strobe
    '{1'b1, 1'b0, 8'd4,  8'd64, 10'd4,   4'd1, 10'd2,   2'd1, 1'b1}   // R7 exact 2 lines
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // one negedge: observe outputs, then drive pins for the next posedge
  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (prevStb) strobeCnt++;
      if (vResetOut) begin
        resetCnt++;
        lastCnt  = strobeCnt;
        lastLoad = vLoadLine;
      end
      ph = (ph + 1) % LC;
      lineStb = (ph == 0);
      prevStb = lineStb;
      hdIn = hdOn ? (ph >= 3) : 1'b1;
      vdSyncIn = csyncOn ? (ph >= 3) : (vdLow == 0);
      if (vdLow > 0) vdLow--;
      vrefIn = (refLow == 0);
      if (refLow > 0) refLow--;
    end
  endtask

  task automatic waitPhase(input int p);
    while (ph != p) step(1);
  endtask

  task automatic clearCounts();
    strobeCnt = 0;
    resetCnt = 0;
    lastCnt = 0;
  endtask

  initial begin
    int curVdhd;
    curVdhd = 2;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(extOut == 1'b0, "R1 extOut", extOut, 0);
    check(vResetOut == 1'b0, "R1 vResetOut", vResetOut, 0);
    check(fieldOdd == 1'b1, "R1 fieldOdd", fieldOdd, 1);

    for (int i = 0; i < 7; i++) begin
      vec_t v;
      v = VECS[i];
      ccirSel = v.ccir;
      if (int'(v.isVdhd) != curVdhd) begin
        curVdhd = int'(v.isVdhd);
        if (v.isVdhd) begin
          csyncOn = 1'b0; hdOn = 1'b1; extSelIn = 1'b1;
          step(8 * LC);
          waitPhase(20);
          vdLow = 96;
          step(6 * LC);
          check(extOut == 1'b1, "R4 extOut in H/V mode", extOut, 1);
        end else begin
          csyncOn = 1'b1; hdOn = 1'b0; extSelIn = 1'b0;
          step(6 * LC);
          check(extOut == 1'b1, "R3 extOut in composite mode", extOut, 1);
        end
      end
      waitPhase(int'(v.fallPh));
      clearCounts();
      if (v.isVdhd) vdLow = int'(v.width);
      else          refLow = int'(v.width);
      step(int'(v.waitLines) * LC);
      check(resetCnt == int'(v.expResets), $sformatf("R5-row%0d reset count (R7 R9)", i),
            resetCnt, int'(v.expResets));
      if (v.expResets != 0) begin
        check(lastCnt == int'(v.expCnt), $sformatf("R6 row%0d strobe position", i),
              lastCnt, int'(v.expCnt));
        check(lastLoad == v.expLoad, $sformatf("R7 row%0d load line", i),
              lastLoad, v.expLoad);
      end
      check(fieldOdd == v.expField, $sformatf("R8 row%0d fieldOdd", i),
            fieldOdd, v.expField);
    end

    // R10: long vertical period keeps external, then timeout
    step(900 * LC);
    check(extOut == 1'b1, "R10 long period still external", extOut, 1);
    step(200 * LC);
    check(extOut == 1'b0, "R10 timeout to internal", extOut, 0);

    // R2: all pins idle, a reference fall is ignored
    extSelIn = 1'b0; hdOn = 1'b0;
    step(8 * LC);
    check(extOut == 1'b0, "R2 idle pins internal", extOut, 0);
    waitPhase(8);
    clearCounts();
    refLow = 8;
    step(262 * LC);
    check(resetCnt == 0, "R2 no request in internal", resetCnt, 0);
    check(extOut == 1'b0, "R2 still internal", extOut, 0);

    // R10: loss of hd in H/V mode
    extSelIn = 1'b1; hdOn = 1'b1;
    step(8 * LC);
    waitPhase(20);
    vdLow = 96;
    step(6 * LC);
    check(extOut == 1'b1, "R4 H/V reacquired", extOut, 1);
    hdOn = 1'b0;
    step(7 * LC);
    check(extOut == 1'b0, "R10 hd loss to internal", extOut, 0);

    // R11: second reference fall restarts the composite count
    csyncOn = 1'b1; extSelIn = 1'b0; ccirSel = 1'b0;
    step(6 * LC);
    check(extOut == 1'b1, "R3 composite reacquired", extOut, 1);
    waitPhase(8);
    refLow = 8;
    step(100 * LC);
    waitPhase(8);
    clearCounts();
    refLow = 8;
    step(262 * LC);
    check(resetCnt == 1, "R11 single request after restart", resetCnt, 1);
    check(lastCnt == 259, "R11 count from second fall", lastCnt, 259);

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule